// File: doc/BRIEF.md
# Free-Running Compare Timer

This block is a memory-mapped timer for a 32-bit register bus. A 32-bit up-counter advances on tick pulses from one of several clock-enable inputs, chosen by a source field in the control word. A programmable prescaler sits between the chosen tick and the counter. The counter cannot be loaded. It runs freely and wraps from all ones to zero, or, in restart mode, returns to zero after it matches compare channel 0.

Each compare channel raises its own sticky status flag when the counter reaches the channel's value. A flag drives the interrupt line when its enable bit is set. A rollover flag records each wrap. Software clears flags by writing ones to them. To re-arm a channel, software adds a period to a counter value it has just read.

A self-timed soft reset returns the registers to zero, except for the clock-selection and low-power bits of the control word. Four low-power mode inputs freeze counting unless the matching run bit is set.

Top module: `gp_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The prescale register holds N-1, and the counter advances once per N selected ticks. Writing the prescale register restarts the divide phase.
- R3: In free-run mode (control bit 9 = 1), the counter counts through compare matches. It wraps from all ones to 0, and the wrap sets status bit N_CMP, the rollover flag (bit 3 by default).
- R4: Compare channel k sits at offset 0x10+4k. When the counter becomes equal to it, status bit k is set. `irq` is high while any status bit is set together with the same bit of the enable register at 0x0C.
- R5: Writing the status register at 0x08 clears exactly the bits written as 1, and bits written as 0 are unaffected. A flag that sets in the same cycle as its clear stays set.
- R6: Control bits 3:1 select the tick source: 0 none, 1 peripheral, 2 doubled peripheral, 3 external, 4 slow, 5 fast. Codes 6 and 7 also select no source. With no source the counter halts. The fast source counts only when control bit 4 is also set.
- R7: The low-power inputs stop, doze, wait and debug freeze the counter and prescaler while asserted, unless run bit 5, 6, 7 or 8 respectively is set.
- R8: Control bit 0 enables counting. Clearing it holds the count, and setting it again resumes from the held value.
- R9: Writing 1 to control bit 15 starts a soft reset that lasts SRST_CYCLES cycles. Bit 15 reads 1 during the reset and 0 afterwards. Writes are ignored while the reset runs.
- R10: The soft reset zeroes the counter, prescale, status, enable and compare registers, and control bits 0 and 9. Control bits 8:1 are kept.
- R11: In restart mode (control bit 9 = 0), the counter returns to 0 on the tick after it equals compare channel 0.
- R12: `req_ready` is always high. A read returns its data with `rsp_valid` in the next cycle. The counter reads at 0x24. Unmapped or misaligned addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| tick_periph | input | 1 | Peripheral tick enable |
| tick_periph2x | input | 1 | Doubled peripheral tick enable |
| tick_ext | input | 1 | External tick enable |
| tick_32k | input | 1 | Slow tick enable |
| tick_24m | input | 1 | Fast tick enable |
| lp_stop | input | 1 | Stop mode active |
| lp_doze | input | 1 | Doze mode active |
| lp_wait | input | 1 | Wait mode active |
| lp_debug | input | 1 | Debug mode active |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are the wrap from all ones and a match that lands in the same cycle as its own clear. The counter cannot be loaded, so the bench builds the block with an 8-bit counter and drives every tick pulse by hand. This reaches the wrap in a few hundred cycles with an exactly known count. For the collision, a task issues the status write and the tick pulse in the same cycle. The counter has been placed one tick before a compare value that was just rewritten, so the match and the clear meet exactly.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int CR_EN     = 0;
  localparam int CR_SRC_LO = 1;
  localparam int CR_EN24   = 4;
  localparam int CR_RSTOP  = 5;
  localparam int CR_RDOZE  = 6;
  localparam int CR_RWAIT  = 7;
  localparam int CR_RDBG   = 8;
  localparam int CR_FRR    = 9;
  localparam int CR_SWR    = 15;
  localparam int CR_W      = 10;
  localparam logic [CR_W-1:0] CR_KEEP = 10'h1FE;

  typedef enum logic [2:0] {
    SRC_OFF      = 3'd0,
    SRC_PERIPH   = 3'd1,
    SRC_PERIPH2X = 3'd2,
    SRC_EXT      = 3'd3,
    SRC_SLOW     = 3'd4,
    SRC_FAST     = 3'd5
  } clk_src_e;

  localparam int RI_CR   = 0;
  localparam int RI_PR   = 1;
  localparam int RI_SR   = 2;
  localparam int RI_IER  = 3;
  localparam int RI_OCR0 = 4;
  localparam int RI_CNT  = 9;
endpackage

// File: rtl/gpt_prescale.sv
module gpt_prescale import gpt_pkg::*; #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [2:0]       src,
  input  logic             en24,
  input  logic [3:0]       run_lp,
  input  logic [PRE_W-1:0] pr,
  input  logic             pr_wr,
  input  logic             busy,
  input  logic             tick_periph,
  input  logic             tick_periph2x,
  input  logic             tick_ext,
  input  logic             tick_32k,
  input  logic             tick_24m,
  input  logic             lp_stop,
  input  logic             lp_doze,
  input  logic             lp_wait,
  input  logic             lp_debug,
  output logic             cnt_pulse
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic src_tick, frozen, advance, at_end;

  always_comb begin
    case (clk_src_e'(src))
      SRC_PERIPH:   src_tick = tick_periph;
      SRC_PERIPH2X: src_tick = tick_periph2x;
      SRC_EXT:      src_tick = tick_ext;
      SRC_SLOW:     src_tick = tick_32k;
      SRC_FAST:     src_tick = tick_24m & en24;
      default:      src_tick = 1'b0;
    endcase
  end

  assign frozen  = (lp_stop  & ~run_lp[0]) | (lp_doze  & ~run_lp[1]) |
                   (lp_wait  & ~run_lp[2]) | (lp_debug & ~run_lp[3]);
  assign advance = en & ~busy & ~frozen & src_tick;
  assign at_end  = (pre_q == pr);
  assign cnt_pulse = advance & at_end;

  always_comb begin
    pre_d = pre_q;
    if (busy || pr_wr)  pre_d = '0;
    else if (advance)   pre_d = at_end ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W = 32,
  parameter int N_CMP = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        pulse,
  input  logic                        frr,
  input  logic [N_CMP-1:0][CNT_W-1:0] ocr,
  output logic [CNT_W-1:0]            cnt,
  output logic [N_CMP-1:0]            match_set,
  output logic                        wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic restart, step;

  assign restart = ~frr & (cnt_q == ocr[0]);
  assign step    = pulse & ~clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)        cnt_d = '0;
    else if (pulse) cnt_d = restart ? '0 : cnt_q + 1'b1;
  end

  assign wrap = step & ~restart & (cnt_q == {CNT_W{1'b1}});

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    assign match_set[k] = step & (cnt_d == ocr[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/gpt_regs.sv
module gpt_regs import gpt_pkg::*; #(
  parameter int CNT_W       = 32,
  parameter int PRE_W       = 12,
  parameter int N_CMP       = 3,
  parameter int ADDR_W      = 8,
  parameter int SRST_CYCLES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [31:0]                 req_wdata,
  output logic                        req_ready,
  output logic                        rsp_valid,
  output logic [31:0]                 rsp_rdata,
  input  logic [CNT_W-1:0]            cnt,
  input  logic [N_CMP-1:0]            match_set,
  input  logic                        wrap,
  output logic [CR_W-1:0]             cr,
  output logic [PRE_W-1:0]            pr,
  output logic                        pr_wr,
  output logic                        busy,
  output logic [N_CMP-1:0][CNT_W-1:0] ocr,
  output logic [N_CMP:0]              sr,
  output logic [N_CMP:0]              ier
);
  localparam int SR_W   = N_CMP + 1;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int BUSY_W = $clog2(SRST_CYCLES + 1);
  localparam logic [IDX_W-1:0] A_CR   = IDX_W'(RI_CR);
  localparam logic [IDX_W-1:0] A_PR   = IDX_W'(RI_PR);
  localparam logic [IDX_W-1:0] A_SR   = IDX_W'(RI_SR);
  localparam logic [IDX_W-1:0] A_IER  = IDX_W'(RI_IER);
  localparam logic [IDX_W-1:0] A_OCR0 = IDX_W'(RI_OCR0);
  localparam logic [IDX_W-1:0] A_CNT  = IDX_W'(RI_CNT);

  logic [CR_W-1:0]             cr_q, cr_d;
  logic [PRE_W-1:0]            pr_q, pr_d;
  logic [SR_W-1:0]             sr_q, sr_d, sr_clr;
  logic [SR_W-1:0]             ier_q, ier_d;
  logic [N_CMP-1:0][CNT_W-1:0] ocr_q, ocr_d;
  logic [BUSY_W-1:0]           busy_q, busy_d;
  logic                        rsp_valid_q;
  logic [31:0]                 rsp_rdata_q, rd_mux;
  logic [IDX_W-1:0]            widx;
  logic                        aligned, wr_acc, rd_acc, start_srst;

  assign widx    = req_addr[ADDR_W-1:2];
  assign aligned = (req_addr[1:0] == 2'b00);
  assign busy    = (busy_q != '0);
  assign wr_acc  = req_valid & req_write & aligned & ~busy;
  assign rd_acc  = req_valid & ~req_write;
  assign start_srst = wr_acc & (widx == A_CR) & req_wdata[CR_SWR];
  assign pr_wr   = wr_acc & (widx == A_PR);
  assign req_ready = 1'b1;

  always_comb begin
    busy_d = busy_q;
    if (start_srst) busy_d = BUSY_W'(SRST_CYCLES);
    else if (busy)  busy_d = busy_q - 1'b1;
  end

  always_comb begin
    cr_d = cr_q;
    if (busy)                          cr_d = cr_q & CR_KEEP;
    else if (start_srst)               cr_d = req_wdata[CR_W-1:0] & CR_KEEP;
    else if (wr_acc && widx == A_CR)   cr_d = req_wdata[CR_W-1:0];
  end

  always_comb begin
    pr_d  = pr_q;
    ier_d = ier_q;
    if (busy) begin
      pr_d  = '0;
      ier_d = '0;
    end else begin
      if (pr_wr)                         pr_d  = req_wdata[PRE_W-1:0];
      if (wr_acc && widx == A_IER)       ier_d = req_wdata[SR_W-1:0];
    end
  end

  always_comb begin
    sr_clr = (wr_acc && widx == A_SR) ? req_wdata[SR_W-1:0] : '0;
    if (busy) sr_d = '0;
    else      sr_d = (sr_q & ~sr_clr) | {wrap, match_set};
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_ocr
    always_comb begin
      ocr_d[k] = ocr_q[k];
      if (busy) ocr_d[k] = '0;
      else if (wr_acc && widx == A_OCR0 + IDX_W'(k))
        ocr_d[k] = req_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (widx)
        A_CR:  begin
          rd_mux[CR_W-1:0] = cr_q;
          rd_mux[CR_SWR]   = busy;
        end
        A_PR:  rd_mux[PRE_W-1:0] = pr_q;
        A_SR:  rd_mux[SR_W-1:0]  = sr_q;
        A_IER: rd_mux[SR_W-1:0]  = ier_q;
        A_CNT: rd_mux[CNT_W-1:0] = cnt;
        default: begin
          for (int k = 0; k < N_CMP; k++)
            if (widx == A_OCR0 + IDX_W'(k)) rd_mux[CNT_W-1:0] = ocr_q[k];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q        <= '0;
      pr_q        <= '0;
      sr_q        <= '0;
      ier_q       <= '0;
      ocr_q       <= '0;
      busy_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      cr_q        <= cr_d;
      pr_q        <= pr_d;
      sr_q        <= sr_d;
      ier_q       <= ier_d;
      ocr_q       <= ocr_d;
      busy_q      <= busy_d;
      rsp_valid_q <= rd_acc;
      if (rd_acc) rsp_rdata_q <= rd_mux;
    end
  end

  assign cr        = cr_q;
  assign pr        = pr_q;
  assign sr        = sr_q;
  assign ier       = ier_q;
  assign ocr       = ocr_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/gp_timer.sv
module gp_timer import gpt_pkg::*; #(
  parameter int CNT_W       = 32,
  parameter int PRE_W       = 12,
  parameter int N_CMP       = 3,
  parameter int ADDR_W      = 8,
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              tick_periph,
  input  logic              tick_periph2x,
  input  logic              tick_ext,
  input  logic              tick_32k,
  input  logic              tick_24m,
  input  logic              lp_stop,
  input  logic              lp_doze,
  input  logic              lp_wait,
  input  logic              lp_debug,
  output logic              irq
);
  logic [1:0]                  rst_sync;
  logic                        rst_int_n;
  logic [CR_W-1:0]             cr_q;
  logic [PRE_W-1:0]            pr_q;
  logic                        pr_wr;
  logic                        srst_busy;
  logic [N_CMP-1:0][CNT_W-1:0] ocr_q;
  logic [N_CMP:0]              sr_q, ier_q;
  logic [CNT_W-1:0]            cnt_q;
  logic [N_CMP-1:0]            match_set;
  logic                        wrap, cnt_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  gpt_regs #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .N_CMP(N_CMP),
    .ADDR_W(ADDR_W), .SRST_CYCLES(SRST_CYCLES)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cnt(cnt_q), .match_set(match_set), .wrap(wrap),
    .cr(cr_q), .pr(pr_q), .pr_wr(pr_wr), .busy(srst_busy),
    .ocr(ocr_q), .sr(sr_q), .ier(ier_q)
  );

  gpt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_int_n),
    .en(cr_q[CR_EN]), .src(cr_q[CR_SRC_LO+2:CR_SRC_LO]), .en24(cr_q[CR_EN24]),
    .run_lp(cr_q[CR_RDBG:CR_RSTOP]),
    .pr(pr_q), .pr_wr(pr_wr), .busy(srst_busy),
    .tick_periph(tick_periph), .tick_periph2x(tick_periph2x),
    .tick_ext(tick_ext), .tick_32k(tick_32k), .tick_24m(tick_24m),
    .lp_stop(lp_stop), .lp_doze(lp_doze), .lp_wait(lp_wait), .lp_debug(lp_debug),
    .cnt_pulse(cnt_pulse)
  );

  gpt_counter #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_cnt (
    .clk(clk), .rst_n(rst_int_n),
    .clr(srst_busy), .pulse(cnt_pulse), .frr(cr_q[CR_FRR]),
    .ocr(ocr_q), .cnt(cnt_q), .match_set(match_set), .wrap(wrap)
  );

  assign irq = |(sr_q & ier_q);
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker import gpt_pkg::*; #(
  parameter int CNT_W = 32,
  parameter int N_CMP = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             rsp_valid,
  input logic             irq,
  input logic             lp_wait,
  input logic [CR_W-1:0]  cr_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             cnt_pulse,
  input logic             srst_busy,
  input logic [N_CMP:0]   sr_q,
  input logic [N_CMP:0]   ier_q,
  input logic [N_CMP-1:0] match_set
);
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R12

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q == '0) |-> !irq); // R4

  AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_pulse && !srst_busy) |=> (cnt_q == $past(cnt_q))); // R2

  AST_WAIT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_wait && !cr_q[CR_RWAIT]) |-> !cnt_pulse); // R7

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (match_set != '0) |=> ((sr_q[N_CMP-1:0] & $past(match_set)) == $past(match_set))); // R5

  AST_SRST_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |=> (cnt_q == '0)); // R10

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pulse && cr_q[CR_FRR] && (cnt_q == {CNT_W{1'b1}})) |=> (cnt_q == '0)); // R3
endmodule

bind gp_timer gpt_checker #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .irq(irq), .lp_wait(lp_wait), .cr_q(cr_q),
  .cnt_q(cnt_q), .cnt_pulse(cnt_pulse), .srst_busy(srst_busy),
  .sr_q(sr_q), .ier_q(ier_q), .match_set(match_set)
);

// File: tb/sim_gp_timer.sv
module sim_gp_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  logic clk, rst_n, req_valid, req_write, req_ready, rsp_valid, irq;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata, rsp_rdata;
  logic tp, tp2, tx, ts, tf, lps, lpd, lpw, lpg;

  int checks = 0, fails = 0;
  bit done = 0;
  exp_t sb[$];

  gp_timer #(.CNT_W(CNT_W), .PRE_W(12), .N_CMP(3), .ADDR_W(8), .SRST_CYCLES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .tick_periph(tp), .tick_periph2x(tp2), .tick_ext(tx), .tick_32k(ts),
    .tick_24m(tf), .lp_stop(lps), .lp_doze(lpd), .lp_wait(lpw), .lp_debug(lpg),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops expected read results as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rsp_rdata !== e.exp) begin
          fails++;
          $display("FAIL %s addr=%h actual=%h expected=%h", e.tag, e.addr, rsp_rdata, e.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  // src: 1 periph, 5 fast
  task automatic tick(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (src == 5) tf = 1; else tp = 1;
      @(negedge clk);
      tf = 0; tp = 0;
    end
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; tp = 1;
    @(negedge clk);
    req_valid = 0; req_write = 0; tp = 0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    tp = 0; tp2 = 0; tx = 0; ts = 0; tf = 0; lps = 0; lpd = 0; lpw = 0; lpg = 0;
    idle(4);
    rst_n = 1;
    idle(4);

    // R1 reset state
    rd(8'h00, 0, "R1 cr"); rd(8'h04, 0, "R1 pr"); rd(8'h08, 0, "R1 sr");
    rd(8'h0C, 0, "R1 ier"); rd(8'h10, 0, "R1 ocr0"); rd(8'h24, 0, "R1 cnt");
    chk_irq(0, "R1");
    // R12 unmapped and misaligned
    rd(8'h40, 0, "R12 unmapped");
    wr(8'h05, 32'h7); rd(8'h04, 0, "R12 misaligned write ignored");
    checks++; if (req_ready !== 1'b1) begin fails++; $display("FAIL R12 ready actual=%b expected=1", req_ready); end

    // R2 prescaler divide by 4
    wr(8'h04, 3);
    wr(8'h00, 32'h203);
    tick(1, 8); rd(8'h24, 2, "R2 div4");
    wr(8'h04, 0);
    tick(1, 5); rd(8'h24, 7, "R2 div1");

    // R4 compare and interrupt
    wr(8'h10, 10);
    tick(1, 2); rd(8'h08, 0, "R4 before match");
    tick(1, 1); rd(8'h08, 1, "R4 match flag");
    chk_irq(0, "R4 masked");
    wr(8'h0C, 1); chk_irq(1, "R4 enabled");
    tick(1, 2); rd(8'h24, 12, "R3 runs through match");

    // R5 write-one-to-clear
    wr(8'h08, 0); rd(8'h08, 1, "R5 zero write");
    wr(8'h08, 1); rd(8'h08, 0, "R5 clear"); chk_irq(0, "R5 irq after clear");
    wr(8'h14, 13); tick(1, 1); rd(8'h08, 2, "R4 channel1");
    wr(8'h14, 14); wr_tick(8'h08, 2); rd(8'h08, 2, "R5 set wins");
    wr(8'h08, 2); rd(8'h08, 0, "R5 clear ch1");

    // R3 wrap (8-bit counter here)
    tick(1, 241); rd(8'h24, 255, "R3 at max"); rd(8'h08, 0, "R3 no flags yet");
    tick(1, 1); rd(8'h24, 0, "R3 wrapped"); rd(8'h08, 32'hC, "R3 rollover and ch2");
    wr(8'h08, 32'hF);
    tick(1, 11); rd(8'h24, 11, "R3 past compare after wrap");
    wr(8'h08, 32'hF);

    // R6 clock source
    wr(8'h00, 32'h20B); tick(5, 3); rd(8'h24, 11, "R6 fast without enable");
    wr(8'h00, 32'h21B); tick(5, 3); rd(8'h24, 14, "R6 fast enabled");
    wr(8'h00, 32'h21B); tick(1, 2); rd(8'h24, 14, "R6 other source ignored");
    wr(8'h00, 32'h201); tick(1, 3); rd(8'h24, 14, "R6 none halts");

    // R7 low power
    wr(8'h00, 32'h203); lpw = 1;
    tick(1, 3); rd(8'h24, 14, "R7 wait frozen");
    wr(8'h00, 32'h283); tick(1, 2); rd(8'h24, 16, "R7 wait run bit");
    lpw = 0;

    // R8 enable hold
    wr(8'h00, 0); rd(8'h24, 16, "R8 held");
    tick(1, 3); rd(8'h24, 16, "R8 disabled");
    wr(8'h00, 32'h203); tick(1, 1); rd(8'h24, 17, "R8 resume");

    // R11 restart mode
    wr(8'h08, 32'hF); wr(8'h10, 19); wr(8'h00, 32'h003);
    tick(1, 2); rd(8'h24, 19, "R11 at compare");
    tick(1, 1); rd(8'h24, 0, "R11 restarted"); rd(8'h08, 32'h5, "R11 flags");

    // R9/R10 soft reset
    wr(8'h04, 2); wr(8'h0C, 7);
    wr(8'h00, 32'h83E3);
    rd(8'h00, 32'h81E2, "R9 busy reads 1");
    wr(8'h04, 5);
    idle(6);
    rd(8'h00, 32'h1E2, "R10 cr kept bits");
    rd(8'h04, 0, "R9 write ignored / R10 pr");
    rd(8'h0C, 0, "R10 ier"); rd(8'h08, 0, "R10 sr");
    rd(8'h10, 0, "R10 ocr0"); rd(8'h24, 0, "R10 cnt");
    chk_irq(0, "R10 irq");

    idle(3);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R12 missing responses actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule